// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is a two-wire bus slave placed in front of a 2048-byte internal memory. It runs on a fast system clock and samples the bus clock and data lines. It drives the data line only through an open-drain enable: a 1 pulls the line low. Both bus inputs first pass through a digital spike filter. The bus logic then finds start, repeated-start and stop conditions from the filtered levels.

A master writes a byte in three steps. It sends a control byte, then the low eight address bits, then the data byte. It reads in one of three ways:
- it reads straight from the current position of the address pointer;
- it first sets the pointer with an address-only write and then reads from there;
- it keeps reading by acknowledging each byte it receives.

The 11-bit pointer keeps its value between transactions. Every completed access moves it forward by one.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset the data-line enable `sda_oe_o` is 0. The slave pulls the line low only for its own acknowledge or for a data 0 bit it is sending.
- R2: The slave responds only when the top four bits of the control byte are 1010. It accepts all eight values of the three bits that follow. For any other code it never acknowledges and stays off the line until the next start.
- R3: In a write, control bit 0 (R/W) is 0. Control bits 3..1 form address bits 10..8, and the next byte forms address bits 7..0. The slave acknowledges all three bytes. At the stop it stores the data byte at that address and leaves the pointer at the address plus one.
- R4: Only one data byte is accepted per write. Later bytes get no acknowledge and change nothing.
- R5: A repeated start after an acknowledged data byte drops that byte. A repeated start straight after the address byte stores nothing. In both cases the pointer keeps the sent address.
- R6: Random read: an address-only write, then a repeated start, then a control byte with R/W = 1. The slave acknowledges and returns the byte at the sent address.
- R7: Current-address read: a control byte with R/W = 1 and no address phase returns the byte one past the last byte read or written.
- R8: Sequential read: each master acknowledge (data line low) after a byte makes the slave send the byte at the next address.
- R9: The pointer steps from 2047 to 0, for both reads and writes.
- R10: A master non-acknowledge (data line high) ends the read. The slave releases the line and waits for a start or stop. After a stop the enable is 0.
- R11: A pulse shorter than `FILT_LEN` system clocks on either bus line is ignored. A level takes effect only after `FILT_LEN` consecutive equal samples.
- R12: Bits travel most significant first in both directions. The slave changes its drive only while the filtered clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Data line level, as seen on the wired bus |
| sda_oe_o | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The bench goes after the boundary cases of the pointer:
- A sequential read that crosses from 2047 to 0. A pointer that failed to wrap would return the wrong byte on the third read.
- A current-address read right after a write. Here an off-by-one shows up as the written byte itself instead of its neighbour.
- A write cut short by a repeated start. A design that commits too early would overwrite the stored byte.

Further checks cover an extra data byte, which must get no acknowledge and must not replace the first byte, and a foreign device code, which must get no acknowledge at all. Short spikes on the clock line in the middle of a write must not add phantom bits. A design without the filter would shift the byte and lose the acknowledge.

// File: rtl/twm_pkg.sv
package twm_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTRL,
    ST_CTRL_ACK,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } twm_state_e;

  // Next address with wrap to zero at the top of an aw-bit space.
  function automatic int unsigned addr_step(int unsigned a, int unsigned aw);
    int unsigned span;
    span = 32'd1 << aw;
    return (a + 1) % span;
  endfunction

  // Device code sits in the four most significant bits of the control byte.
  function automatic logic dev_hit(logic [7:0] ctrl, logic [3:0] code);
    return ctrl[7:4] == code;
  endfunction

endpackage

// File: rtl/twm_deglitch.sv
module twm_deglitch #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic sync_o,
  output logic clean_o
);
  localparam int CW = $clog2(LEN + 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1      <= 1'b1;
      s2      <= 1'b1;
      cnt     <= '0;
      clean_o <= 1'b1;
    end else begin
      s1 <= raw_i;
      s2 <= s1;
      if (s2 == clean_o) begin
        cnt <= '0;
      end else if (cnt == CW'(LEN - 1)) begin
        clean_o <= s2;
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign sync_o = s2;
endmodule

// File: rtl/twm_store.sv
module twm_store #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/twm_engine.sv
module twm_engine
  import twm_pkg::*;
#(
  parameter int          AW       = 11,
  parameter int          DW       = 8,
  parameter logic [3:0]  DEV_CODE = 4'b1010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_f_i,
  input  logic          sda_f_i,
  input  logic [DW-1:0] rdata_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_waddr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic [AW-1:0] ptr_o,
  output logic          sda_oe_o,
  output logic          start_evt_o,
  output logic          stop_evt_o,
  output logic          ptr_inc_o,
  output logic          in_ignore_o
);
  localparam int HI = AW - DW;
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] FULL = CW'(DW);

  twm_state_e    state;
  logic          scl_q, sda_q;
  logic [CW-1:0] bitcnt;
  logic [DW-1:0] shreg;
  logic [HI-1:0] blk;
  logic [AW-1:0] ptr;
  logic          rw, pend, ack_seen, oe;
  logic [DW-1:0] pend_data;

  logic scl_rise, scl_fall, start_evt, stop_evt;
  logic load_evt, commit_evt, addr_evt, ptr_inc;

  // Edge and bus-condition detection on filtered levels.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f_i;
      sda_q <= sda_f_i;
    end
  end

  assign scl_rise  = scl_f_i & ~scl_q;
  assign scl_fall  = ~scl_f_i & scl_q;
  assign start_evt = scl_f_i & scl_q & sda_q & ~sda_f_i;
  assign stop_evt  = scl_f_i & scl_q & ~sda_q & sda_f_i;

  // Pointer events.
  assign load_evt   = !start_evt && !stop_evt && scl_fall &&
                      ((state == ST_CTRL_ACK && rw) || (state == ST_RACK && ack_seen));
  assign commit_evt = stop_evt && pend;
  assign addr_evt   = !start_evt && !stop_evt && scl_fall &&
                      state == ST_ADDR && bitcnt == FULL;
  assign ptr_inc    = load_evt || commit_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (addr_evt) begin
      ptr <= {blk, shreg};
    end else if (ptr_inc) begin
      ptr <= AW'(addr_step(32'(ptr), AW));
    end
  end

  // Protocol sequencer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      blk       <= '0;
      rw        <= 1'b0;
      pend      <= 1'b0;
      pend_data <= '0;
      ack_seen  <= 1'b0;
      oe        <= 1'b0;
    end else if (stop_evt) begin
      state <= ST_IDLE;
      oe    <= 1'b0;
      pend  <= 1'b0;
    end else if (start_evt) begin
      state  <= ST_CTRL;
      bitcnt <= '0;
      oe     <= 1'b0;
      pend   <= 1'b0;
    end else begin
      unique case (state)
        ST_CTRL, ST_ADDR, ST_WDATA: begin
          if (scl_rise && bitcnt != FULL) begin
            shreg  <= {shreg[DW-2:0], sda_f_i};
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall && bitcnt == FULL) begin
            bitcnt <= '0;
            if (state == ST_CTRL) begin
              if (dev_hit(shreg, DEV_CODE)) begin
                rw    <= shreg[0];
                blk   <= shreg[HI:1];
                oe    <= 1'b1;
                state <= ST_CTRL_ACK;
              end else begin
                state <= ST_IGNORE;
              end
            end else if (state == ST_ADDR) begin
              oe    <= 1'b1;
              state <= ST_ADDR_ACK;
            end else if (!pend) begin
              pend_data <= shreg;
              pend      <= 1'b1;
              oe        <= 1'b1;
              state     <= ST_WDATA_ACK;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        ST_CTRL_ACK: begin
          if (scl_fall) begin
            if (rw) begin
              shreg  <= rdata_i;
              oe     <= ~rdata_i[DW-1];
              bitcnt <= CW'(1);
              state  <= ST_RDATA;
            end else begin
              oe    <= 1'b0;
              state <= ST_ADDR;
            end
          end
        end
        ST_ADDR_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            oe    <= 1'b0;
            state <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (bitcnt == FULL) begin
              oe       <= 1'b0;
              ack_seen <= 1'b0;
              state    <= ST_RACK;
            end else begin
              oe     <= ~shreg[DW-2];
              shreg  <= {shreg[DW-2:0], 1'b0};
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            ack_seen <= ~sda_f_i;
          end else if (scl_fall) begin
            if (ack_seen) begin
              shreg  <= rdata_i;
              oe     <= ~rdata_i[DW-1];
              bitcnt <= CW'(1);
              state  <= ST_RDATA;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        default: begin
          oe <= 1'b0;
        end
      endcase
    end
  end

  assign mem_we_o    = commit_evt;
  assign mem_waddr_o = ptr;
  assign mem_wdata_o = pend_data;
  assign ptr_o       = ptr;
  assign sda_oe_o    = oe;
  assign start_evt_o = start_evt;
  assign stop_evt_o  = stop_evt;
  assign ptr_inc_o   = ptr_inc;
  assign in_ignore_o = (state == ST_IGNORE) || (state == ST_IDLE);
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave #(
  parameter int         AW       = 11,
  parameter int         DW       = 8,
  parameter int         FILT_LEN = 4,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  logic          scl_f, sda_f, scl_sync, sda_sync;
  logic          mem_we, start_evt, stop_evt, ptr_inc, in_ignore;
  logic [AW-1:0] mem_waddr, ptr;
  logic [DW-1:0] mem_wdata, rdata;

  twm_deglitch #(.LEN(FILT_LEN)) u_scl_filt (
    .clk(clk), .rst_n(rst_n), .raw_i(scl_i), .sync_o(scl_sync), .clean_o(scl_f)
  );

  twm_deglitch #(.LEN(FILT_LEN)) u_sda_filt (
    .clk(clk), .rst_n(rst_n), .raw_i(sda_i), .sync_o(sda_sync), .clean_o(sda_f)
  );

  twm_store #(.AW(AW), .DW(DW)) u_store (
    .clk(clk), .we_i(mem_we), .waddr_i(mem_waddr), .wdata_i(mem_wdata),
    .raddr_i(ptr), .rdata_o(rdata)
  );

  twm_engine #(.AW(AW), .DW(DW), .DEV_CODE(DEV_CODE)) u_engine (
    .clk(clk), .rst_n(rst_n), .scl_f_i(scl_f), .sda_f_i(sda_f), .rdata_i(rdata),
    .mem_we_o(mem_we), .mem_waddr_o(mem_waddr), .mem_wdata_o(mem_wdata),
    .ptr_o(ptr), .sda_oe_o(sda_oe_o), .start_evt_o(start_evt),
    .stop_evt_o(stop_evt), .ptr_inc_o(ptr_inc), .in_ignore_o(in_ignore)
  );
endmodule

// File: rtl/twm_chk.sv
module twm_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_f,
  input logic          scl_sync,
  input logic          sda_oe_o,
  input logic          start_evt,
  input logic          stop_evt,
  input logic          ptr_inc,
  input logic          in_ignore,
  input logic          mem_we,
  input logic [AW-1:0] ptr
);
  // R12: drive changes happen only while the filtered clock is low
  a_r12_drive_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe_o) && !$past(stop_evt) && !$past(start_evt)) |-> !scl_f);

  // R10: line is released after a stop
  a_r10_release_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe_o);

  // R2: never pull the line while ignoring the bus
  a_r2_quiet_when_ignoring: assert property (@(posedge clk) disable iff (!rst_n)
    in_ignore |-> !sda_oe_o);

  // R9: pointer wraps from the top address to zero
  a_r9_pointer_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_inc && ptr == {AW{1'b1}}) |=> ptr == '0);

  // R3: memory is written only on a stop
  a_r3_write_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> stop_evt);

  // R11: the filtered clock only moves to the synchronised level
  a_r11_filter_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_f) |-> scl_f == scl_sync);
endmodule

bind twi_mem_slave twm_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .scl_sync(scl_sync),
  .sda_oe_o(sda_oe_o), .start_evt(start_evt), .stop_evt(stop_evt),
  .ptr_inc(ptr_inc), .in_ignore(in_ignore), .mem_we(mem_we), .ptr(ptr)
);

// File: tb/sim_twi_mem_slave.sv
module sim_twi_mem_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_bus;
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 0;

  assign sda_bus = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  twi_mem_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic scl_spike();
    @(negedge clk) scl_m = 1'b1;
    repeat (2) @(negedge clk);
    scl_m = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b1; wait_q(); wait_q();
  endtask

  task automatic put_bit(input bit b, input bit glitch);
    sda_m = b;
    if (glitch) scl_spike();
    wait_q();
    scl_m = 1'b1; wait_q(); wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic get_bit(output bit b);
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    b = sda_bus;
    wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] d, input bit glitch, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) put_bit(d[i], glitch);
    get_bit(b);
    ack = !b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input bit m_ack);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(!m_ack, 1'b0);
  endtask

  task automatic wr_byte(input logic [10:0] a, input logic [7:0] d, output bit ok);
    bit a0, a1, a2;
    bus_start();
    send_byte({4'hA, a[10:8], 1'b0}, 1'b0, a0);
    send_byte(a[7:0], 1'b0, a1);
    send_byte(d, 1'b0, a2);
    bus_stop();
    ok = a0 && a1 && a2;
  endtask

  task automatic rd_random(input logic [10:0] a, output logic [7:0] d);
    bit k;
    bus_start();
    send_byte({4'hA, a[10:8], 1'b0}, 1'b0, k);
    send_byte(a[7:0], 1'b0, k);
    bus_start();
    send_byte({4'hA, a[10:8], 1'b1}, 1'b0, k);
    recv_byte(d, 1'b0);
    bus_stop();
  endtask

  task automatic rd_current(output logic [7:0] d);
    bit k;
    bus_start();
    send_byte(8'hA1, 1'b0, k);
    recv_byte(d, 1'b0);
    bus_stop();
  endtask

  task automatic sc_reset();
    check(sda_oe == 1'b0, "R1 enable low after reset", int'(sda_oe), 0);
  endtask

  task automatic sc_write_read();
    bit ok;
    logic [7:0] d;
    wr_byte(11'h123, 8'h5A, ok);
    check(ok, "R3 write acknowledged", int'(ok), 1);
    wr_byte(11'h124, 8'hC3, ok);
    rd_random(11'h123, d);
    check(d == 8'h5A, "R6 random read", int'(d), 'h5A);
    rd_current(d);
    check(d == 8'hC3, "R7 current read after read", int'(d), 'hC3);
  endtask

  task automatic sc_ptr_after_write();
    bit ok;
    logic [7:0] d;
    wr_byte(11'h301, 8'h22, ok);
    wr_byte(11'h300, 8'h11, ok);
    rd_current(d);
    check(d == 8'h22, "R3 R7 pointer after write", int'(d), 'h22);
    wr_byte(11'h060, 8'h01, ok);
    rd_random(11'h060, d);
    check(d == 8'h01, "R12 bit order round trip", int'(d), 1);
  endtask

  task automatic sc_seq_wrap();
    bit ok, k;
    logic [7:0] d;
    wr_byte(11'h7FE, 8'hA1, ok);
    wr_byte(11'h7FF, 8'hB2, ok);
    check(ok, "R9 write at top acknowledged", int'(ok), 1);
    wr_byte(11'h000, 8'hC3, ok);
    wr_byte(11'h001, 8'hD4, ok);
    bus_start();
    send_byte(8'hAE, 1'b0, k);
    send_byte(8'hFE, 1'b0, k);
    bus_start();
    send_byte(8'hAF, 1'b0, k);
    check(k, "R6 read control acknowledged", int'(k), 1);
    recv_byte(d, 1'b1);
    check(d == 8'hA1, "R8 sequential byte 0", int'(d), 'hA1);
    recv_byte(d, 1'b1);
    check(d == 8'hB2, "R8 sequential byte 1", int'(d), 'hB2);
    recv_byte(d, 1'b1);
    check(d == 8'hC3, "R9 sequential wrap to 0", int'(d), 'hC3);
    recv_byte(d, 1'b0);
    check(d == 8'hD4, "R8 sequential byte 3", int'(d), 'hD4);
    bus_stop();
    repeat (4) @(negedge clk);
    check(sda_oe == 1'b0, "R10 released after nack and stop", int'(sda_oe), 0);
    wr_byte(11'h7FF, 8'hB2, ok);
    rd_current(d);
    check(d == 8'hC3, "R9 write wrap then current read", int'(d), 'hC3);
  endtask

  task automatic sc_bad_code();
    bit k;
    logic [7:0] d;
    bus_start();
    send_byte(8'hB0, 1'b0, k);
    check(!k, "R2 foreign code not acknowledged", int'(k), 0);
    send_byte(8'h00, 1'b0, k);
    check(!k, "R2 stays off bus after foreign code", int'(k), 0);
    bus_stop();
    rd_random(11'h123, d);
    check(d == 8'h5A, "R2 memory intact", int'(d), 'h5A);
  endtask

  task automatic sc_extra_byte();
    bit ok, k;
    logic [7:0] d;
    wr_byte(11'h041, 8'h99, ok);
    bus_start();
    send_byte(8'hA0, 1'b0, k);
    send_byte(8'h40, 1'b0, k);
    send_byte(8'h77, 1'b0, k);
    send_byte(8'h88, 1'b0, k);
    check(!k, "R4 second data byte not acknowledged", int'(k), 0);
    bus_stop();
    rd_random(11'h040, d);
    check(d == 8'h77, "R4 first data byte kept", int'(d), 'h77);
    rd_current(d);
    check(d == 8'h99, "R4 neighbour untouched", int'(d), 'h99);
  endtask

  task automatic sc_abort_write();
    bit ok, k;
    logic [7:0] d;
    wr_byte(11'h550, 8'h33, ok);
    bus_start();
    send_byte(8'hAA, 1'b0, k);
    send_byte(8'h50, 1'b0, k);
    send_byte(8'h44, 1'b0, k);
    check(k, "R5 data byte acknowledged", int'(k), 1);
    bus_start();
    send_byte(8'hAB, 1'b0, k);
    recv_byte(d, 1'b0);
    bus_stop();
    check(d == 8'h33, "R5 cut write not committed", int'(d), 'h33);
  endtask

  task automatic sc_glitch();
    bit a0, a1, a2;
    logic [7:0] d;
    bus_start();
    send_byte(8'hA0, 1'b1, a0);
    send_byte(8'h70, 1'b1, a1);
    send_byte(8'h96, 1'b1, a2);
    bus_stop();
    check(a0 && a1 && a2, "R11 spikes ignored, acks intact", int'({a0, a1, a2}), 7);
    rd_random(11'h070, d);
    check(d == 8'h96, "R11 spiked write stored", int'(d), 'h96);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    sc_reset();
    sc_write_read();
    sc_ptr_after_write();
    sc_seq_wrap();
    sc_bad_code();
    sc_extra_byte();
    sc_abort_write();
    sc_glitch();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule